// File: doc/BRIEF.md
# UART Transmitter with Break Sequencing

This block is the transmit half of an asynchronous serial port. A one-word holding slot sits in front of a frame shifter. Software-side logic writes a word into the slot. The shifter takes the word on a bit-rate tick and sends it as a frame: a low start bit, the data least significant bit first, then a high stop bit. A mode input picks 8 or 9 data bits per frame. The block reports whether the slot is free and whether everything queued has been sent.

A break input makes the transmitter send line-break frames. Each one is a whole frame time of zeros, and it moves through the slot and the shifter exactly as a character does. While break is held, complete zero frames follow one another with no gap. Once break is released, the last break frame ends and the line is held high for at least one bit time before any further start bit. Each time the enable input rises, the transmitter first sends one frame time of all ones and only then sends anything queued.

Baud-rate generation is outside the block. It receives a single-cycle `bit_tick` once per bit period, and every line bit lasts exactly one tick interval.

Top module: `uart_brk_tx`

## Requirements
- R1: After reset the line output is 1, and both `buf_empty` and `tx_done` are 1.
- R2: A data frame is sent as a 0 start bit, then `wr_data[7:0]` least significant bit first, then a 1 stop bit. When `mode9`=1, `wr_data[8]` is sent between bit 7 and the stop bit. Each bit lasts one tick interval. When the slot is refilled in time, frames follow each other with no idle bit between them.
- R3: `buf_empty` is 0 in the cycle after a write. It returns to 1 after the tick on which the slot contents move into the shifter.
- R4: `tx_done` is 0 in the cycle after a write. It becomes 1 when the shifter finishes and no entry is waiting.
- R5: When `tx_en` rises, one all-ones frame (10 bits for `mode9`=0, 11 bits for `mode9`=1) is sent before any queued entry.
- R6: A break frame is 10 consecutive 0 bits when `mode9`=0 and 11 consecutive 0 bits when `mode9`=1.
- R7: While `brk` stays 1, break frames follow each other with no gap, and a break frame is never cut short.
- R8: After a break frame that is not followed by another break frame, the line is 1 for at least one bit time before the next start bit.
- R9: A break entry is put in the slot whenever `brk`=1 and the slot is free or is being emptied. Holding `brk` across a load therefore queues one more break frame behind the one in progress. A queued break entry makes `buf_empty` 0.
- R10: While `tx_en`=0, nothing moves into the shifter. The line stays 1 and the slot contents are kept.
- R11: A write takes priority over a break request in the same cycle, and it replaces a break entry that is waiting in the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| tx_en | input | 1 | Transmitter enable |
| mode9 | input | 1 | 1: nine data bits, 0: eight data bits |
| brk | input | 1 | Break request |
| wr_en | input | 1 | Slot write strobe |
| wr_data | input | 9 | Word to send (bit 8 used only when mode9=1) |
| txd | output | 1 | Serial line, idles high |
| buf_empty | output | 1 | Holding slot is free |
| tx_done | output | 1 | All queued frames have been sent |

## Verification
The bench sends every 8-bit value, and then every 9-bit value, back to back. It decodes the line at each tick and compares each frame with a frame built arithmetically from the word. A wrong bit order, a missing ninth bit or an idle bit between frames therefore shows up immediately.

The break cases are these:
- A short break request queues exactly two zero frames. A transmitter that queued only one, or that kept going, gives the wrong frame count.
- A data word written during the second break frame must start exactly one bit after that frame ends. A design without the forced high bit starts it at once.
- A held break released mid-frame must still end with whole zero frames. A design that truncated the frame would decode as a frame containing ones.

The enable-rise preamble is checked by the distance from the enable edge to the first start bit. Dropping the preamble shortens that distance to one or two bits.

// File: rtl/uart_brk_tx_pkg.sv
package uart_brk_tx_pkg;

    typedef enum logic [1:0] {
        FK_DATA  = 2'd0,
        FK_BREAK = 2'd1,
        FK_IDLE  = 2'd2
    } frame_kind_e;

    typedef enum logic [1:0] {
        SH_IDLE = 2'd0,
        SH_SEND = 2'd1,
        SH_MARK = 2'd2
    } shift_state_e;

endpackage

// File: rtl/uart_brk_tx_slot.sv
module uart_brk_tx_slot
    import uart_brk_tx_pkg::*;
#(
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              brk_req,
    input  logic              pop,
    output logic              full,
    output frame_kind_e       kind,
    output logic [WORD_W-1:0] word
);

    typedef struct packed {
        logic              full;
        frame_kind_e       kind;
        logic [WORD_W-1:0] word;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (pop) begin
            slot_d.full = 1'b0;
        end
        if (wr_en) begin
            // write beats a break request and replaces a waiting break entry
            slot_d.full = 1'b1;
            slot_d.kind = FK_DATA;
            slot_d.word = wr_data;
        end else if (brk_req && (!slot_q.full || pop)) begin
            slot_d.full = 1'b1;
            slot_d.kind = FK_BREAK;
            slot_d.word = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q.full <= 1'b0;
            slot_q.kind <= FK_DATA;
            slot_q.word <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign full = slot_q.full;
    assign kind = slot_q.kind;
    assign word = slot_q.word;

    // R11: a write always leaves a data entry in the slot
    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (slot_q.full && slot_q.kind == FK_DATA));

endmodule

// File: rtl/uart_brk_tx_frame.sv
module uart_brk_tx_frame
    import uart_brk_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  mode9,
    input  frame_kind_e           kind,
    input  logic [DATA_W:0]       word,
    output logic [DATA_W+2:0]     frame,
    output logic [$clog2(DATA_W+4)-1:0] len
);

    localparam int FRAME_MAX = DATA_W + 3;
    localparam int CNT_W     = $clog2(FRAME_MAX + 1);

    logic [FRAME_MAX-1:0] data_frame;

    assign data_frame[0] = 1'b0;
    for (genvar i = 0; i < DATA_W; i++) begin : g_data_bit
        assign data_frame[i+1] = word[i];
    end
    assign data_frame[DATA_W+1] = mode9 ? word[DATA_W] : 1'b1;
    assign data_frame[DATA_W+2] = 1'b1;

    always_comb begin
        len = mode9 ? CNT_W'(DATA_W + 3) : CNT_W'(DATA_W + 2);
        case (kind)
            FK_BREAK: frame = '0;
            FK_IDLE:  frame = '1;
            default:  frame = data_frame;
        endcase
    end

endmodule

// File: rtl/uart_brk_tx_shift.sv
module uart_brk_tx_shift
    import uart_brk_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           tick,
    input  logic                           src_valid,
    input  frame_kind_e                    src_kind,
    input  logic [DATA_W+2:0]              src_frame,
    input  logic [$clog2(DATA_W+4)-1:0]    src_len,
    output logic                           take,
    output logic                           went_idle,
    output logic                           txd
);

    localparam int FRAME_MAX = DATA_W + 3;
    localparam int CNT_W     = $clog2(FRAME_MAX + 1);

    typedef struct packed {
        shift_state_e         state;
        frame_kind_e          kind;
        logic [FRAME_MAX-1:0] sr;
        logic [CNT_W-1:0]     cnt;
        logic [CNT_W-1:0]     len;
    } shift_t;

    shift_t sh_d, sh_q;
    logic   last_bit;
    logic   free;

    assign last_bit = (sh_q.state == SH_SEND) && (sh_q.cnt == sh_q.len - CNT_W'(1));

    always_comb begin
        sh_d      = sh_q;
        take      = 1'b0;
        went_idle = 1'b0;
        free      = 1'b0;
        if (tick) begin
            case (sh_q.state)
                SH_SEND: begin
                    if (last_bit) begin
                        // a break not chained to another break ends with a mark bit
                        if (sh_q.kind == FK_BREAK && !(src_valid && src_kind == FK_BREAK)) begin
                            sh_d.state = SH_MARK;
                        end else begin
                            free = 1'b1;
                        end
                    end else begin
                        sh_d.sr  = {1'b1, sh_q.sr[FRAME_MAX-1:1]};
                        sh_d.cnt = sh_q.cnt + CNT_W'(1);
                    end
                end
                default: free = 1'b1;
            endcase
            if (free) begin
                if (src_valid) begin
                    take       = 1'b1;
                    sh_d.state = SH_SEND;
                    sh_d.kind  = src_kind;
                    sh_d.sr    = src_frame;
                    sh_d.cnt   = '0;
                    sh_d.len   = src_len;
                end else if (sh_q.state != SH_IDLE) begin
                    sh_d.state = SH_IDLE;
                    went_idle  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q.state <= SH_IDLE;
            sh_q.kind  <= FK_DATA;
            sh_q.sr    <= '1;
            sh_q.cnt   <= '0;
            sh_q.len   <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign txd = (sh_q.state == SH_SEND) ? sh_q.sr[0] : 1'b1;

    // R6: every bit of a break frame on the line is low
    a_r6_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q.state == SH_SEND && sh_q.kind == FK_BREAK) |-> !txd);

    // R2: a data frame opens with a low start bit
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q.state == SH_SEND && sh_q.kind == FK_DATA && sh_q.cnt == '0) |-> !txd);

    // R2: a data frame closes with a high stop bit
    a_r2_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q.state == SH_SEND && sh_q.kind == FK_DATA && last_bit) |-> txd);

    // R7: a frame in progress is never abandoned between ticks
    a_r7_no_truncate: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q.state == SH_SEND && !last_bit) |=> (sh_q.state == SH_SEND));

endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx
    import uart_brk_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              tx_en,
    input  logic              mode9,
    input  logic              brk,
    input  logic              wr_en,
    input  logic [DATA_W:0]   wr_data,
    output logic              txd,
    output logic              buf_empty,
    output logic              tx_done
);

    localparam int WORD_W    = DATA_W + 1;
    localparam int FRAME_MAX = DATA_W + 3;
    localparam int CNT_W     = $clog2(FRAME_MAX + 1);

    typedef struct packed {
        logic en_prev;
        logic pend_idle;
        logic done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                 slot_full;
    frame_kind_e          slot_kind;
    logic [WORD_W-1:0]    slot_word;
    logic                 src_valid;
    frame_kind_e          src_kind;
    logic [FRAME_MAX-1:0] src_frame;
    logic [CNT_W-1:0]     src_len;
    logic                 take;
    logic                 went_idle;
    logic                 pop;

    assign src_valid = tx_en && (ctl_q.pend_idle || slot_full);
    assign src_kind  = ctl_q.pend_idle ? FK_IDLE : slot_kind;
    assign pop       = take && !ctl_q.pend_idle;

    uart_brk_tx_slot #(.WORD_W(WORD_W)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .brk_req (brk),
        .pop     (pop),
        .full    (slot_full),
        .kind    (slot_kind),
        .word    (slot_word)
    );

    uart_brk_tx_frame #(.DATA_W(DATA_W)) u_frame (
        .mode9 (mode9),
        .kind  (src_kind),
        .word  (slot_word),
        .frame (src_frame),
        .len   (src_len)
    );

    uart_brk_tx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (bit_tick),
        .src_valid (src_valid),
        .src_kind  (src_kind),
        .src_frame (src_frame),
        .src_len   (src_len),
        .take      (take),
        .went_idle (went_idle),
        .txd       (txd)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.en_prev = tx_en;
        if (tx_en && !ctl_q.en_prev) begin
            ctl_d.pend_idle = 1'b1;
        end else if (take && ctl_q.pend_idle) begin
            ctl_d.pend_idle = 1'b0;
        end
        if (wr_en) begin
            ctl_d.done = 1'b0;
        end else if (went_idle && !slot_full) begin
            ctl_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.en_prev   <= 1'b0;
            ctl_q.pend_idle <= 1'b0;
            ctl_q.done      <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign buf_empty = !slot_full;
    assign tx_done   = ctl_q.done;

    // R3: a slot handed to the shifter reads as free next cycle
    a_r3_empty_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !ctl_q.pend_idle && !wr_en && !brk) |=> buf_empty);

    // R4: a write always clears the completion flag
    a_r4_done_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tx_done);

    // R10: nothing is loaded while disabled
    a_r10_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !take);

    // R5: an enable edge schedules the all-ones preamble
    a_r5_preamble_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !ctl_q.en_prev) |=> ctl_q.pend_idle);

endmodule

// File: tb/uart_brk_tx_test.sv
module uart_brk_tx_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       tx_en = 1'b0;
    logic       mode9 = 1'b0;
    logic       brk = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       txd;
    logic       buf_empty;
    logic       tx_done;

    always #4 clk = ~clk;

    uart_brk_tx #(.DATA_W(8)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .tx_en     (tx_en),
        .mode9     (mode9),
        .brk       (brk),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .txd       (txd),
        .buf_empty (buf_empty),
        .tx_done   (tx_done)
    );

    int checks = 0;
    int errors = 0;

    // tick generator and line decoder
    int          tick_div = 0;
    int          samples = 0;
    int          dec_len = 10;
    bit          dec_busy = 1'b0;
    int          dec_n = 0;
    logic [10:0] dec_bits = '0;
    int          gap = 0;
    logic [10:0] fr_bits [1024];
    int          fr_gap [1024];
    int          fr_t [1024];
    int          fr_wr = 0;
    int          fr_rd = 0;

    always @(negedge clk) begin
        bit_tick = 1'b0;
        if (rst_n) begin
            tick_div++;
            if (tick_div == 4) begin
                tick_div = 0;
                bit_tick = 1'b1;
                samples++;
                if (!dec_busy) begin
                    if (txd == 1'b0) begin
                        dec_busy = 1'b1;
                        dec_bits = '0;
                        dec_n    = 1;
                        fr_t[fr_wr % 1024] = samples;
                    end else begin
                        gap++;
                    end
                end else begin
                    dec_bits[dec_n] = txd;
                    dec_n++;
                    if (dec_n == dec_len) begin
                        fr_bits[fr_wr % 1024] = dec_bits;
                        fr_gap[fr_wr % 1024]  = gap;
                        gap      = 0;
                        dec_busy = 1'b0;
                        fr_wr++;
                    end
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [10:0] exp_frame(input logic [8:0] v, input bit m9);
        if (m9) return {1'b1, v, 1'b0};
        return {1'b0, 1'b1, v[7:0], 1'b0};
    endfunction

    task automatic wait_ticks(input int n);
        repeat (n) @(posedge bit_tick);
        @(negedge clk);
    endtask

    task automatic write_word(input logic [8:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        check(buf_empty == 1'b0, "R3 slot taken after write", int'(buf_empty), 0);
        check(tx_done == 1'b0, "R4 done cleared by write", int'(tx_done), 0);
    endtask

    task automatic get_frame(output logic [10:0] b, output int g, output int t);
        wait (fr_wr > fr_rd);
        b = fr_bits[fr_rd % 1024];
        g = fr_gap[fr_rd % 1024];
        t = fr_t[fr_rd % 1024];
        fr_rd++;
    endtask

    task automatic sweep(input bit m9);
        logic [10:0] b;
        int g;
        int t;
        int n;
        n = m9 ? 512 : 256;
        for (int v = 0; v < n; v++) begin
            while (!buf_empty) @(negedge clk);
            write_word(9'(v));
        end
        for (int v = 0; v < n; v++) begin
            get_frame(b, g, t);
            check(b == exp_frame(9'(v), m9), "R2 data frame bits", int'(b), int'(exp_frame(9'(v), m9)));
            if (v > 0) check(g == 0, "R2 back-to-back frames", g, 0);
        end
        wait_ticks(15);
        check(tx_done == 1'b1, "R4 done after last frame", int'(tx_done), 1);
        check(buf_empty == 1'b1, "R3 slot free when drained", int'(buf_empty), 1);
    endtask

    initial begin
        logic [10:0] b;
        int g;
        int t;
        int t0;
        int base;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd == 1'b1, "R1 line high after reset", int'(txd), 1);
        check(buf_empty == 1'b1, "R1 slot free after reset", int'(buf_empty), 1);
        check(tx_done == 1'b1, "R1 done after reset", int'(tx_done), 1);

        // disabled: a break entry then a write that replaces it
        wait_ticks(3);
        base = fr_wr;
        @(negedge clk);
        brk = 1'b1;
        @(negedge clk);
        brk = 1'b0;
        @(negedge clk);
        check(buf_empty == 1'b0, "R9 break entry occupies slot", int'(buf_empty), 0);
        write_word(9'h055);
        wait_ticks(30);
        check(fr_wr == base, "R10 no frame while disabled", fr_wr - base, 0);
        check(txd == 1'b1, "R10 line high while disabled", int'(txd), 1);
        check(buf_empty == 1'b0, "R10 slot kept while disabled", int'(buf_empty), 0);

        // enable right after a tick: preamble then the data word
        wait_ticks(1);
        t0 = samples;
        tx_en = 1'b1;
        get_frame(b, g, t);
        check(b == exp_frame(9'h055, 1'b0), "R11 write replaced queued break", int'(b), int'(exp_frame(9'h055, 1'b0)));
        check((t - t0) >= 11 && (t - t0) <= 13, "R5 all-ones frame before first data", t - t0, 12);
        wait_ticks(15);
        check(tx_done == 1'b1, "R4 done after single frame", int'(tx_done), 1);

        // exhaustive data sweeps
        sweep(1'b0);
        mode9   = 1'b1;
        dec_len = 11;
        sweep(1'b1);

        // short break request: two zero frames, then mark bit before data
        mode9   = 1'b0;
        dec_len = 10;
        base    = fr_wr;
        @(negedge clk);
        brk = 1'b1;
        @(negedge clk);
        @(posedge bit_tick);
        @(negedge clk);
        @(negedge clk);
        brk = 1'b0;
        get_frame(b, g, t);
        check(b == 11'd0, "R6 break frame of ten zeros", int'(b), 0);
        write_word(9'h0C3);
        get_frame(b, g, t);
        check(b == 11'd0, "R6 second break frame zeros", int'(b), 0);
        check(g == 0, "R7 queued break follows without gap", g, 0);
        get_frame(b, g, t);
        check(b == exp_frame(9'h0C3, 1'b0), "R8 data after break", int'(b), int'(exp_frame(9'h0C3, 1'b0)));
        check(g == 1, "R8 one mark bit after break", g, 1);
        wait_ticks(15);
        check(fr_wr == base + 3, "R9 exactly two break frames queued", fr_wr - base, 3);

        // held break in nine-bit mode, released mid-frame
        mode9   = 1'b1;
        dec_len = 11;
        base    = fr_wr;
        @(negedge clk);
        brk = 1'b1;
        wait (fr_wr == base + 3);
        repeat (7) @(negedge clk);
        brk = 1'b0;
        wait_ticks(40);
        check(fr_wr == base + 5, "R7 held break count", fr_wr - base, 5);
        for (int i = 0; i < 5; i++) begin
            get_frame(b, g, t);
            check(b == 11'd0, "R6 eleven-zero break frame", int'(b), 0);
            if (i > 0) check(g == 0, "R7 continuous break frames", g, 0);
        end
        check(txd == 1'b1, "R8 line high after break", int'(txd), 1);
        check(tx_done == 1'b1, "R4 done after break", int'(tx_done), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got %0d expected %0d", 150000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule